// File: doc/BRIEF.md
# Scratchpad Replica Coalescing Buffer

This block sits between the scratchpad write port and the cache that keeps duplicate copies of dirty scratchpad lines. It holds one line of eight 32-bit words, which is 32 bytes, together with that line's tag and a per-word written mask. Scratchpad writes that stay inside the held line are merged into the buffer and cause no cache traffic. The cache sees a request only when the scratchpad moves to a different line or when a flush is asked for.

When a write falls in a different line, the write is accepted at once and parked. The buffered line is then offered to the cache as one request carrying tag, data and word enables. Once the cache acknowledges it, the buffer is reloaded with only the parked word. The cache decides whether it overwrites the replica it already has for that tag or allocates a fresh line. A flush drains the buffer in the same way and leaves it empty, for example before an error recovery pass. While a request is outstanding, or while flush is raised, the scratchpad side sees not-ready.

Top module: `replica_wbuf`

## Requirements
- R1: After reset the buffer is empty, wr_ready is 1 and wb_valid is 0.
- R2: A write accepted while the buffer is empty loads it with no write-back request. The buffer is empty after reset and after a flush drain.
- R3: A write address splits into a tag (bits 31:5), a word index (bits 4:2) and a byte offset (bits 1:0). The byte offset is ignored.
- R4: A write whose tag equals the buffered tag updates that word in place, sets its mask bit and raises no write-back request.
- R5: A write whose tag differs from a valid buffered tag is accepted. In the next cycle wb_valid rises with the old tag, mask and data. After the acknowledge the buffer holds only the new word under the new tag.
- R6: Once raised, wb_valid stays high with wb_tag, wb_mask and wb_data unchanged until a cycle with wb_ready high. wr_ready is 0 for that whole time, and the acknowledge cycle is followed by wb_valid 0.
- R7: wb_mask bit i is 1 exactly when word i has been written since the line was loaded. Word i occupies wb_data[32*i+31:32*i], and a later write to the same word replaces its value.
- R8: Flush on a valid buffer raises a write-back of the line, after which the buffer is empty. Flush on an empty buffer raises no request.
- R9: wr_ready is 0 in any cycle with flush high. A write presented alongside the flush is held off, is not part of the drained line, and is taken after the drain completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_valid | input | 1 | Scratchpad write present |
| wr_ready | output | 1 | Write can be taken this cycle |
| wr_addr | input | 32 | Scratchpad byte address of the write |
| wr_data | input | 32 | Written word |
| flush | input | 1 | Drain the buffered line and leave the buffer empty |
| wb_valid | output | 1 | Line write-back request to the cache |
| wb_ready | input | 1 | Cache acknowledge of the write-back |
| wb_tag | output | 27 | Line address of the written-back line |
| wb_mask | output | 8 | Word enables of the written-back line |
| wb_data | output | 256 | Eight words of the written-back line, word 0 lowest |

## Verification
Two functions can meet in one cycle. A flush can arrive together with a write, and a write-back acknowledge can arrive while a write is already waiting. The bench raises flush and a same-line write on the same edge. It judges that wr_ready is low during the flush, and that the drained line holds only the earlier word. The bench keeps the write asserted through the acknowledge. It then judges that the write is taken on the first ready edge and loads the emptied buffer without a second request. Stall lengths of zero to three cycles confirm that the payload holds steady until the acknowledge.

// File: rtl/rwb_pkg.sv
package rwb_pkg;
  typedef enum logic {
    RWB_IDLE  = 1'b0,
    RWB_DRAIN = 1'b1
  } rwb_state_e;
endpackage

// File: rtl/rwb_rst_sync.sv
module rwb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/rwb_line.sv
module rwb_line #(
  parameter int WORD_W = 32,
  parameter int WORDS  = 8,
  parameter int IDX_W  = 3,
  parameter int TAG_W  = 27
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    op_merge,
  input  logic                    op_fresh,
  input  logic                    op_inval,
  input  logic [TAG_W-1:0]        in_tag,
  input  logic [IDX_W-1:0]        in_idx,
  input  logic [WORD_W-1:0]       in_data,
  output logic                    line_vld,
  output logic [TAG_W-1:0]        line_tag,
  output logic [WORDS*WORD_W-1:0] line_data,
  output logic [WORDS-1:0]        line_mask
);
  logic [WORDS-1:0] idx_hot;
  logic             wr_any;
  logic             vld_d;
  logic [TAG_W-1:0] tag_d;
  logic [WORDS-1:0] mask_d;

  assign idx_hot = {{(WORDS-1){1'b0}}, 1'b1} << in_idx;
  assign wr_any  = op_merge | op_fresh;

  always_comb begin
    vld_d  = line_vld;
    tag_d  = line_tag;
    mask_d = line_mask;
    if (op_inval) begin
      vld_d  = 1'b0;
      mask_d = '0;
    end else if (op_fresh) begin
      vld_d  = 1'b1;
      tag_d  = in_tag;
      mask_d = idx_hot;
    end else if (op_merge) begin
      vld_d  = 1'b1;
      tag_d  = in_tag;
      mask_d = line_mask | idx_hot;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_vld  <= 1'b0;
      line_tag  <= '0;
      line_mask <= '0;
    end else begin
      line_vld  <= vld_d;
      line_tag  <= tag_d;
      line_mask <= mask_d;
    end
  end

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic word_we;
    assign word_we = wr_any & idx_hot[w];
    always_ff @(posedge clk) begin
      if (word_we) line_data[w*WORD_W +: WORD_W] <= in_data;
    end
  end

  // R7: a live line always has at least one written word, an empty one none
  a_r7_mask_live: assert property (@(posedge clk) disable iff (!rst_n)
    line_vld |-> (line_mask != '0));
  a_r7_mask_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !line_vld |-> (line_mask == '0));
endmodule

// File: rtl/rwb_ctrl.sv
module rwb_ctrl
  import rwb_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int IDX_W  = 3,
  parameter int TAG_W  = 27
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              flush,
  input  logic              wb_ack,
  input  logic              line_vld,
  input  logic [TAG_W-1:0]  line_tag,
  output logic              wr_ready,
  output logic              wb_valid,
  output logic              op_merge,
  output logic              op_fresh,
  output logic              op_inval,
  output logic [TAG_W-1:0]  sel_tag,
  output logic [IDX_W-1:0]  sel_idx,
  output logic [WORD_W-1:0] sel_data
);
  rwb_state_e        state_q, state_d;
  logic              pend_vld_q, pend_vld_d;
  logic              pend_cap;
  logic [TAG_W-1:0]  pend_tag_q;
  logic [IDX_W-1:0]  pend_idx_q;
  logic [WORD_W-1:0] pend_data_q;
  logic              accept;
  logic              hit;
  logic              in_drain;

  assign in_drain = (state_q == RWB_DRAIN);
  assign wr_ready = !in_drain && !flush;
  assign wb_valid = in_drain;
  assign accept   = wr_valid && wr_ready;
  assign hit      = line_vld && (line_tag == wr_tag);

  always_comb begin
    state_d    = state_q;
    pend_vld_d = pend_vld_q;
    pend_cap   = 1'b0;
    op_merge   = 1'b0;
    op_fresh   = 1'b0;
    op_inval   = 1'b0;
    unique case (state_q)
      RWB_IDLE: begin
        if (accept) begin
          if (hit) begin
            op_merge = 1'b1;
          end else if (!line_vld) begin
            op_fresh = 1'b1;
          end else begin
            pend_cap   = 1'b1;
            pend_vld_d = 1'b1;
            state_d    = RWB_DRAIN;
          end
        end else if (flush && line_vld) begin
          pend_vld_d = 1'b0;
          state_d    = RWB_DRAIN;
        end
      end
      RWB_DRAIN: begin
        if (wb_ack) begin
          if (pend_vld_q) op_fresh = 1'b1;
          else            op_inval = 1'b1;
          pend_vld_d = 1'b0;
          state_d    = RWB_IDLE;
        end
      end
      default: state_d = RWB_IDLE;
    endcase
  end

  assign sel_tag  = in_drain ? pend_tag_q  : wr_tag;
  assign sel_idx  = in_drain ? pend_idx_q  : wr_idx;
  assign sel_data = in_drain ? pend_data_q : wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= RWB_IDLE;
      pend_vld_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      pend_vld_q <= pend_vld_d;
    end
  end

  always_ff @(posedge clk) begin
    if (pend_cap) begin
      pend_tag_q  <= wr_tag;
      pend_idx_q  <= wr_idx;
      pend_data_q <= wr_data;
    end
  end

  // R6: request held and scratchpad stalled until acknowledged
  a_r6_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_ack) |=> (wb_valid && !wr_ready));
  // R8: a drain with nothing parked leaves the line empty
  a_r8_drain_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (in_drain && wb_ack && !pend_vld_q) |=> !line_vld);
  // R5: a drain with a parked write leaves the line valid
  a_r5_parked_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (in_drain && wb_ack && pend_vld_q) |=> line_vld);
endmodule

// File: rtl/replica_wbuf.sv
module replica_wbuf #(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  parameter int WORDS  = 8,
  localparam int OFF_W = $clog2(WORD_W / 8),
  localparam int IDX_W = $clog2(WORDS),
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_valid,
  output logic                    wr_ready,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [WORD_W-1:0]       wr_data,
  input  logic                    flush,
  output logic                    wb_valid,
  input  logic                    wb_ready,
  output logic [TAG_W-1:0]        wb_tag,
  output logic [WORDS-1:0]        wb_mask,
  output logic [WORDS*WORD_W-1:0] wb_data
);
  logic              rst_sync_n;
  logic [TAG_W-1:0]  wr_tag;
  logic [IDX_W-1:0]  wr_idx;
  logic              unused_off;
  logic              op_merge, op_fresh, op_inval;
  logic [TAG_W-1:0]  sel_tag;
  logic [IDX_W-1:0]  sel_idx;
  logic [WORD_W-1:0] sel_data;
  logic              line_vld;
  logic              accept;

  assign wr_tag     = wr_addr[ADDR_W-1 -: TAG_W];
  assign wr_idx     = wr_addr[OFF_W +: IDX_W];
  assign unused_off = ^wr_addr[OFF_W-1:0];
  assign accept     = wr_valid && wr_ready;

  rwb_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  rwb_ctrl #(.WORD_W(WORD_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_valid (wr_valid),
    .wr_tag   (wr_tag),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .flush    (flush),
    .wb_ack   (wb_ready),
    .line_vld (line_vld),
    .line_tag (wb_tag),
    .wr_ready (wr_ready),
    .wb_valid (wb_valid),
    .op_merge (op_merge),
    .op_fresh (op_fresh),
    .op_inval (op_inval),
    .sel_tag  (sel_tag),
    .sel_idx  (sel_idx),
    .sel_data (sel_data)
  );

  rwb_line #(.WORD_W(WORD_W), .WORDS(WORDS), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_line (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .op_merge  (op_merge),
    .op_fresh  (op_fresh),
    .op_inval  (op_inval),
    .in_tag    (sel_tag),
    .in_idx    (sel_idx),
    .in_data   (sel_data),
    .line_vld  (line_vld),
    .line_tag  (wb_tag),
    .line_data (wb_data),
    .line_mask (wb_mask)
  );

  // R2: a write into an empty buffer loads it without a request
  a_r2_empty_load: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (accept && !line_vld) |=> (!wb_valid && line_vld));
  // R4: a same-line write merges without cache traffic
  a_r4_hit_merge: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (accept && line_vld && (wb_tag == wr_tag)) |=> (!wb_valid && wb_mask[$past(wr_idx)]));
  // R5: a different-line write drains the old line
  a_r5_miss_drain: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (accept && line_vld && (wb_tag != wr_tag)) |=> (wb_valid && (wb_tag == $past(wb_tag))));
  // R6: payload steady while the cache stalls
  a_r6_payload_stable: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wb_valid && !wb_ready) |=> ($stable(wb_tag) && $stable(wb_mask) && $stable(wb_data)));
  // R5: after an acknowledge at most the parked word remains
  a_r5_after_ack: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wb_valid && wb_ready) |=> (!wb_valid && ($countones(wb_mask) <= 1)));
endmodule

// File: tb/replica_wbuf_tb.sv
`timescale 1ns/1ps
module replica_wbuf_tb;
  typedef struct packed {
    logic [31:0] addr;
    logic [31:0] data;
    logic        exp_wb;
    logic [3:0]  delay;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{32'h1000_0000, 32'hA000_0001, 1'b0, 4'd0},  // R2 empty load
    '{32'h1000_0004, 32'hA000_0002, 1'b0, 4'd0},  // R4 hit
    '{32'h1000_001C, 32'hA000_0003, 1'b0, 4'd0},  // R4 last word
    '{32'h1000_0004, 32'hA000_0004, 1'b0, 4'd0},  // R7 rewrite word
    '{32'h1000_0020, 32'hA000_0005, 1'b1, 4'd0},  // R5 next line
    '{32'h1000_003C, 32'hA000_0006, 1'b0, 4'd0},  // R4
    '{32'h1000_0000, 32'hA000_0007, 1'b1, 4'd3},  // R5 back, stall
    '{32'h2000_0008, 32'hA000_0008, 1'b1, 4'd1},  // R5
    '{32'h2000_000B, 32'hA000_0009, 1'b0, 4'd0}   // R3 byte offset
  };

  logic         clk = 1'b0;
  logic         rst_n;
  logic         wr_valid, wr_ready, flush, wb_valid, wb_ready;
  logic [31:0]  wr_addr, wr_data;
  logic [26:0]  wb_tag;
  logic [7:0]   wb_mask;
  logic [255:0] wb_data;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  logic        m_vld;
  logic [26:0] m_tag;
  logic [7:0]  m_mask;
  logic [31:0] m_data [8];

  logic        c_vld  [4];
  logic [26:0] c_tag  [4];
  logic [31:0] c_data [4][8];
  int          c_cnt = 0;

  always #5 clk = ~clk;

  replica_wbuf u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .flush(flush), .wb_valid(wb_valid),
    .wb_ready(wb_ready), .wb_tag(wb_tag), .wb_mask(wb_mask), .wb_data(wb_data)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      n_chk++;
      n_fail++;
      $display("FAIL R6 watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic model_load(input logic [31:0] addr, input logic [31:0] data);
    logic [26:0] t;
    int i;
    t = addr[31:5];
    i = int'(addr[4:2]);
    if (!(m_vld && m_tag == t)) m_mask = '0;
    m_vld     = 1'b1;
    m_tag     = t;
    m_mask[i] = 1'b1;
    m_data[i] = data;
  endtask

  // called at a negedge with a request expected to be up
  task automatic serve_wb(input string req, input int delay);
    int slot;
    chk(req, "wb_valid", wb_valid, 1'b1);
    chk("R6", "wr_ready while draining", wr_ready, 1'b0);
    chk("R5", "wb_tag", wb_tag, m_tag);
    chk("R7", "wb_mask", wb_mask, m_mask);
    for (int i = 0; i < 8; i++)
      if (m_mask[i]) chk("R7", "wb word", wb_data[i*32 +: 32], m_data[i]);
    for (int d = 0; d < delay; d++) begin
      @(negedge clk);
      chk("R6", "held valid", wb_valid, 1'b1);
      chk("R6", "held tag", wb_tag, m_tag);
      chk("R6", "held mask", wb_mask, m_mask);
    end
    slot = -1;
    for (int s = 0; s < 4; s++)
      if (c_vld[s] && c_tag[s] == m_tag) slot = s;
    if (slot < 0) begin
      slot = c_cnt;
      c_cnt++;
      c_vld[slot] = 1'b1;
      c_tag[slot] = m_tag;
    end
    for (int i = 0; i < 8; i++)
      if (wb_mask[i]) c_data[slot][i] = wb_data[i*32 +: 32];
    wb_ready = 1'b1;
    @(negedge clk);
    wb_ready = 1'b0;
    chk("R6", "valid drops after ack", wb_valid, 1'b0);
    m_vld  = 1'b0;
    m_mask = '0;
  endtask

  task automatic do_write(input logic [31:0] addr, input logic [31:0] data,
                          input logic exp_wb, input int delay);
    chk("R6", "wr_ready before write", wr_ready, 1'b1);
    wr_valid = 1'b1;
    wr_addr  = addr;
    wr_data  = data;
    @(negedge clk);
    wr_valid = 1'b0;
    if (exp_wb) begin
      serve_wb("R5", delay);
      chk("R5", "ready after drain", wr_ready, 1'b1);
    end else begin
      chk("R4", "no request on hit or empty load", wb_valid, 1'b0);
    end
    model_load(addr, data);
  endtask

  task automatic do_flush(input string req, input int delay);
    flush = 1'b1;
    #1;
    chk("R9", "wr_ready under flush", wr_ready, 1'b0);
    @(negedge clk);
    flush = 1'b0;
    serve_wb(req, delay);
  endtask

  initial begin
    rst_n = 1'b0; wr_valid = 1'b0; wr_addr = '0; wr_data = '0;
    flush = 1'b0; wb_ready = 1'b0;
    m_vld = 1'b0; m_tag = '0; m_mask = '0;
    for (int i = 0; i < 8; i++) m_data[i] = '0;
    for (int s = 0; s < 4; s++) begin
      c_vld[s] = 1'b0; c_tag[s] = '0;
      for (int i = 0; i < 8; i++) c_data[s][i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "wr_ready after reset", wr_ready, 1'b1);
    chk("R1", "wb_valid after reset", wb_valid, 1'b0);
    chk("R1", "mask after reset", wb_mask, 8'h00);

    for (int v = 0; v < NV; v++)
      do_write(VEC[v].addr, VEC[v].data, VEC[v].exp_wb, int'(VEC[v].delay));

    // R3: byte offset 3 landed on word 2 of the same line
    do_flush("R8", 2);
    chk("R8", "empty after flush", wb_valid, 1'b0);
    // cache side: first line replica overwritten in place, three lines allocated
    chk("R5", "replica lines allocated", c_cnt, 3);
    chk("R5", "replica word0 overwritten", c_data[0][0], 32'hA000_0007);
    chk("R7", "replica word1 last value", c_data[0][1], 32'hA000_0004);
    chk("R4", "replica word7", c_data[0][7], 32'hA000_0003);
    chk("R3", "byte offset merged word2", c_data[2][2], 32'hA000_0009);

    // R8: flush of an empty buffer raises nothing
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    chk("R8", "no request on empty flush", wb_valid, 1'b0);
    @(negedge clk);
    chk("R8", "still no request", wb_valid, 1'b0);
    chk("R8", "ready after empty flush", wr_ready, 1'b1);

    // R9: flush and write on the same edge
    do_write(32'h3000_0000, 32'hB000_0010, 1'b0, 0);
    flush    = 1'b1;
    wr_valid = 1'b1;
    wr_addr  = 32'h3000_0004;
    wr_data  = 32'hB000_0011;
    #1;
    chk("R9", "ready low with flush and write", wr_ready, 1'b0);
    @(negedge clk);
    flush = 1'b0;
    chk("R9", "held write not merged", wb_mask, 8'h01);
    serve_wb("R9", 0);
    @(negedge clk);
    wr_valid = 1'b0;
    chk("R2", "held write loads without request", wb_valid, 1'b0);
    model_load(32'h3000_0004, 32'hB000_0011);
    do_flush("R9", 1);
    chk("R9", "drained line empty", wb_mask, 8'h00);

    // R2 after flush: a new write loads with no request
    do_write(32'h4000_0040, 32'hC000_0001, 1'b0, 0);
    do_flush("R8", 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule